// File: doc/BRIEF.md
# UART Interrupt and Line Status Controller

This block produces the interrupt request, the interrupt status register (ISR) value and the line status register (LSR) value for one channel of a FIFO-buffered UART. It does not store characters. It observes the occupancy of the receive FIFO, the empty flags on the transmit side, and the error flags that the receive datapath attaches to characters. It also sees the CPU's read strobes for ISR and LSR and its write strobe for the transmit holding register (THR).

Three interrupt sources are ranked by priority: a latched line error first, then receive data at the trigger level, then the transmit FIFO going empty. Each source is masked by its own enable bit. When all enable bits are zero, the channel works in polled mode. In that mode the request line stays low, and software reads the LSR, which keeps updating.

Top module: `uart_irq_lsr`

## Requirements
- R1: The trigger level comes from `trig_sel_i` while `fifo_en_i` is 1: 0 selects 1 byte, 1 selects DEPTH/4, 2 selects DEPTH/2 and 3 selects DEPTH-2 (1, 4, 8 and 14 when DEPTH is 16). While `fifo_en_i` is 0 the level is 1.
- R2: With `ier_i[0]` set, the receive source is pending exactly while `rx_count_i` is at or above the trigger level. It drops as soon as the count falls below that level.
- R3: ISR reads 0x01 when no source is pending. Otherwise ISR[0] is 0 and ISR[3:1] holds the winning source: 3'b011 for a line error, 3'b010 for receive data, 3'b001 for transmit empty, in that priority. ISR[7:6] both equal `fifo_en_i` and ISR[5:4] are 0. `irq_o` is high exactly when ISR[0] is 0.
- R4: LSR[0] is 1 while `rx_count_i` is nonzero and 0 when it is zero.
- R5: LSR[5] equals `tx_fifo_empty_i`. LSR[6] is 1 only when both `tx_fifo_empty_i` and `tx_shift_empty_i` are 1.
- R6: The transmit source becomes pending when `ier_i[1]` goes from 0 to 1 while the transmit FIFO is empty. It also becomes pending when the transmit FIFO goes from not-empty to empty after at least one THR write since the previous such event.
- R7: A THR write clears the pending transmit source. An ISR read clears it when the ISR value being read shows the transmit code.
- R8: Once cleared, the transmit source does not return while the FIFO stays empty and no THR write occurs.
- R9: On `head_adv_i`, the flags `head_err_i[3:0]` (overrun, parity, framing, break) are ORed into LSR[1], LSR[2], LSR[3] and LSR[4]. On `rx_push_i` with any bit of `push_err_i` set, LSR[7] sets. These bits are sticky until an LSR read clears them, but flags that arrive in the same cycle as the read survive it. With `ier_i[2]` set, any of LSR[4:1] makes the line source pending.
- R10: With `ier_i` all zero, `irq_o` stays 0 and ISR reads with bit 0 set, while the LSR keeps following its inputs.
- R11: All outputs are registered and reflect inputs one clock later. After reset `irq_o` is 0, ISR is 0x01 and LSR is 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | FIFO mode enable |
| ier_i | input | 3 | Enables: [0] receive data, [1] transmit empty, [2] line error |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty |
| tx_shift_empty_i | input | 1 | Transmit shift register empty |
| rx_push_i | input | 1 | A character entered the receive FIFO |
| push_err_i | input | 4 | Error flags of the entering character |
| head_adv_i | input | 1 | A new character reached the FIFO head |
| head_err_i | input | 4 | Flags of the new head character |
| isr_rd_i | input | 1 | ISR read strobe |
| lsr_rd_i | input | 1 | LSR read strobe |
| thr_wr_i | input | 1 | THR write strobe |
| irq_o | output | 1 | Interrupt request |
| isr_o | output | 8 | ISR read value |
| lsr_o | output | 8 | LSR read value |

## Verification
The hardest situations to reach are those that depend on history. The first is the transmit source, which must fire only on a fresh empty edge after a write, and must not fire when the FIFO simply stays empty after an ISR read. The second is an LSR read that coincides with a new error flag. The stimulus reaches them with directed sequences: enable the interrupt on an empty FIFO, clear it by reading, hold the FIFO empty for several cycles, then write and drain. For the error bits, the bench stacks break, overrun and parity flags and then pulses a read in the same cycle as a head advance. A table of steady-state vectors covers the trigger levels and the priority encoding first.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_TX   = 3'b001,
    SRC_RX   = 3'b010,
    SRC_LINE = 3'b011
  } irq_src_e;

  localparam int unsigned ERR_W = 4;
endpackage

// File: rtl/rx_trig_cmp.sv
module rx_trig_cmp #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  output logic             rx_hit_o
);
  localparam logic [CNT_W-1:0] LVL_0 = CNT_W'(1);
  localparam logic [CNT_W-1:0] LVL_1 = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] LVL_2 = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] LVL_3 = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0] level;

  always_comb begin
    if (!fifo_en_i) level = LVL_0;
    else begin
      case (trig_sel_i)
        2'd0:    level = LVL_0;
        2'd1:    level = LVL_1;
        2'd2:    level = LVL_2;
        default: level = LVL_3;
      endcase
    end
  end

  assign rx_hit_o = (rx_count_i >= level);
endmodule

// File: rtl/lsr_err_track.sv
module lsr_err_track
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             head_adv_i,
  input  logic [ERR_W-1:0] head_err_i,
  input  logic             rx_push_i,
  input  logic [ERR_W-1:0] push_err_i,
  input  logic             lsr_rd_i,
  output logic [ERR_W-1:0] err_next_o,
  output logic             ferr_next_o
);
  logic [ERR_W-1:0] err_q;
  logic             ferr_q;

  always_comb begin
    err_next_o  = (lsr_rd_i ? '0 : err_q) | (head_adv_i ? head_err_i : '0);
    ferr_next_o = (lsr_rd_i ? 1'b0 : ferr_q) | (rx_push_i & (|push_err_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      ferr_q <= 1'b0;
    end else begin
      err_q  <= err_next_o;
      ferr_q <= ferr_next_o;
    end
  end
endmodule

// File: rtl/thre_arm.sv
module thre_arm (
  input  logic clk,
  input  logic rst,
  input  logic tx_empty_i,
  input  logic ier_tx_i,
  input  logic thr_wr_i,
  input  logic isr_rd_tx_i,
  output logic pend_next_o
);
  logic empty_d, ier_d, armed_q, pend_q;
  logic edge_set, en_set, armed_next;

  always_comb begin
    edge_set    = tx_empty_i & ~empty_d & armed_q;
    en_set      = ier_tx_i & ~ier_d & tx_empty_i;
    pend_next_o = (thr_wr_i | isr_rd_tx_i) ? 1'b0 : (pend_q | edge_set | en_set);
    if (thr_wr_i)      armed_next = 1'b1;
    else if (edge_set) armed_next = 1'b0;
    else               armed_next = armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_d <= 1'b1;
      ier_d   <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_d <= tx_empty_i;
      ier_d   <= ier_tx_i;
      armed_q <= armed_next;
      pend_q  <= pend_next_o;
    end
  end
endmodule

// File: rtl/uart_irq_lsr.sv
module uart_irq_lsr
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en_i,
  input  logic [2:0]       ier_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             tx_fifo_empty_i,
  input  logic             tx_shift_empty_i,
  input  logic             rx_push_i,
  input  logic [3:0]       push_err_i,
  input  logic             head_adv_i,
  input  logic [3:0]       head_err_i,
  input  logic             isr_rd_i,
  input  logic             lsr_rd_i,
  input  logic             thr_wr_i,
  output logic             irq_o,
  output logic [7:0]       isr_o,
  output logic [7:0]       lsr_o
);
  logic             rx_hit, tx_pend, ferr_next, isr_rd_tx;
  logic [ERR_W-1:0] err_next;
  irq_src_e         src;
  logic [7:0]       isr_next, lsr_next;

  rx_trig_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .fifo_en_i  (fifo_en_i),
    .trig_sel_i (trig_sel_i),
    .rx_count_i (rx_count_i),
    .rx_hit_o   (rx_hit)
  );

  lsr_err_track u_err (
    .clk         (clk),
    .rst         (rst),
    .head_adv_i  (head_adv_i),
    .head_err_i  (head_err_i),
    .rx_push_i   (rx_push_i),
    .push_err_i  (push_err_i),
    .lsr_rd_i    (lsr_rd_i),
    .err_next_o  (err_next),
    .ferr_next_o (ferr_next)
  );

  assign isr_rd_tx = isr_rd_i & (isr_o[3:1] == SRC_TX);

  thre_arm u_thre (
    .clk         (clk),
    .rst         (rst),
    .tx_empty_i  (tx_fifo_empty_i),
    .ier_tx_i    (ier_i[1]),
    .thr_wr_i    (thr_wr_i),
    .isr_rd_tx_i (isr_rd_tx),
    .pend_next_o (tx_pend)
  );

  always_comb begin
    if (ier_i[2] && (|err_next)) src = SRC_LINE;
    else if (ier_i[0] && rx_hit) src = SRC_RX;
    else if (ier_i[1] && tx_pend) src = SRC_TX;
    else                          src = SRC_NONE;
    isr_next = {fifo_en_i, fifo_en_i, 2'b00, src, (src == SRC_NONE)};
    lsr_next = {ferr_next, tx_fifo_empty_i & tx_shift_empty_i, tx_fifo_empty_i,
                err_next, (rx_count_i != '0)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      isr_o <= 8'h01;
      lsr_o <= 8'h60;
    end else begin
      irq_o <= (src != SRC_NONE);
      isr_o <= isr_next;
      lsr_o <= lsr_next;
    end
  end
endmodule

// File: rtl/uart_irq_lsr_chk.sv
module uart_irq_lsr_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en_i,
  input logic [2:0]       ier_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic             rx_push_i,
  input logic             head_adv_i,
  input logic             lsr_rd_i,
  input logic             thr_wr_i,
  input logic             irq_o,
  input logic [7:0]       isr_o,
  input logic [7:0]       lsr_o
);
  // R10: polled mode never raises the request
  a_r10_polled_quiet: assert property (@(posedge clk) disable iff (rst)
    (ier_i == 3'b000) |=> !irq_o);

  // R4: data-ready follows a nonempty FIFO
  a_r4_data_ready: assert property (@(posedge clk) disable iff (rst)
    (rx_count_i != '0) |=> lsr_o[0]);

  // R5: both-empty implies FIFO-empty
  a_r5_temt_implies_thre: assert property (@(posedge clk) disable iff (rst)
    lsr_o[6] |-> lsr_o[5]);

  // R9: an LSR read with no new flags leaves all error bits clear
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd_i && !head_adv_i && !rx_push_i) |=> (lsr_o[4:1] == 4'b0000 && !lsr_o[7]));

  // R7: a THR write removes the transmit code
  a_r7_thr_write_clears: assert property (@(posedge clk) disable iff (rst)
    thr_wr_i |=> (isr_o[3:1] != 3'b001));

  // R2: a full FIFO with receive enable always requests
  a_r2_full_requests: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && ier_i[0] && rx_count_i >= CNT_W'(14)) |=> irq_o);

  // R3: request pin and ISR bit 0 are complements
  a_r3_pin_matches_isr: assert property (@(posedge clk) disable iff (rst)
    irq_o == !isr_o[0]);
endmodule

bind uart_irq_lsr uart_irq_lsr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_en_i  (fifo_en_i),
  .ier_i      (ier_i),
  .rx_count_i (rx_count_i),
  .rx_push_i  (rx_push_i),
  .head_adv_i (head_adv_i),
  .lsr_rd_i   (lsr_rd_i),
  .thr_wr_i   (thr_wr_i),
  .irq_o      (irq_o),
  .isr_o      (isr_o),
  .lsr_o      (lsr_o)
);

// File: tb/uart_irq_lsr_tb.sv
module uart_irq_lsr_tb;
  localparam int CNT_W = 5;
  localparam int VW    = 30;
  localparam int NV    = 12;

  // {fifo_en, ier[2:0], trig, count, txe, tse, exp_irq, exp_isr, exp_lsr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 3'h1, 2'd0, 5'd0,  1'b1, 1'b1, 1'b0, 8'hC1, 8'h60},
    {1'b1, 3'h1, 2'd0, 5'd1,  1'b1, 1'b1, 1'b1, 8'hC4, 8'h61},
    {1'b1, 3'h1, 2'd1, 5'd3,  1'b1, 1'b0, 1'b0, 8'hC1, 8'h21},
    {1'b1, 3'h1, 2'd1, 5'd4,  1'b0, 1'b0, 1'b1, 8'hC4, 8'h01},
    {1'b1, 3'h1, 2'd2, 5'd7,  1'b0, 1'b0, 1'b0, 8'hC1, 8'h01},
    {1'b1, 3'h1, 2'd2, 5'd8,  1'b0, 1'b0, 1'b1, 8'hC4, 8'h01},
    {1'b1, 3'h1, 2'd3, 5'd13, 1'b0, 1'b0, 1'b0, 8'hC1, 8'h01},
    {1'b1, 3'h1, 2'd3, 5'd14, 1'b0, 1'b0, 1'b1, 8'hC4, 8'h01},
    {1'b1, 3'h1, 2'd3, 5'd16, 1'b1, 1'b1, 1'b1, 8'hC4, 8'h61},
    {1'b1, 3'h0, 2'd0, 5'd5,  1'b0, 1'b0, 1'b0, 8'hC1, 8'h01},
    {1'b0, 3'h1, 2'd3, 5'd1,  1'b0, 1'b0, 1'b1, 8'h04, 8'h01},
    {1'b0, 3'h1, 2'd3, 5'd0,  1'b1, 1'b1, 1'b0, 8'h01, 8'h60}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0;
  logic [2:0] ier = 3'b000;
  logic [1:0] trig = 2'd0;
  logic [CNT_W-1:0] cnt = '0;
  logic txe = 1'b1, tse = 1'b1;
  logic rx_push = 1'b0, head_adv = 1'b0;
  logic [3:0] push_err = 4'h0, head_err = 4'h0;
  logic isr_rd = 1'b0, lsr_rd = 1'b0, thr_wr = 1'b0;
  logic irq;
  logic [7:0] isr, lsr;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_lsr #(.DEPTH(16), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .fifo_en_i(fifo_en), .ier_i(ier), .trig_sel_i(trig),
    .rx_count_i(cnt), .tx_fifo_empty_i(txe), .tx_shift_empty_i(tse),
    .rx_push_i(rx_push), .push_err_i(push_err), .head_adv_i(head_adv),
    .head_err_i(head_err), .isr_rd_i(isr_rd), .lsr_rd_i(lsr_rd), .thr_wr_i(thr_wr),
    .irq_o(irq), .isr_o(isr), .lsr_o(lsr)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic e_irq, input logic [7:0] e_isr,
                     input logic [7:0] e_lsr);
    n_run++;
    if (irq !== e_irq || isr !== e_isr || lsr !== e_lsr) begin
      n_fail++;
      $display("FAIL %s: irq/isr/lsr got %0b/%h/%h expected %0b/%h/%h",
               req, irq, isr, lsr, e_irq, e_isr, e_lsr);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 reset state", 1'b0, 8'h01, 8'h60);

    // Table: trigger levels, priority encoding, LSR status bits (R1/R2/R3/R4/R5)
    for (int i = 0; i < NV; i++) begin
      {fifo_en, ier, trig, cnt, txe, tse} = VEC[i][VW-1:17];
      step();
      chk($sformatf("R1/R2/R3/R4/R5 vector %0d", i), VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R6: enabling transmit interrupt on an empty FIFO
    fifo_en = 1'b1; ier = 3'b010; cnt = '0; txe = 1'b1; tse = 1'b1;
    step();
    chk("R6 enable while empty", 1'b1, 8'hC2, 8'h60);
    // R7: ISR read showing transmit code clears it
    isr_rd = 1'b1; step(); isr_rd = 1'b0;
    chk("R7 isr read clears", 1'b0, 8'hC1, 8'h60);
    // R8: no return while FIFO stays empty
    repeat (3) step();
    chk("R8 stays clear while empty", 1'b0, 8'hC1, 8'h60);
    // R6: write then drain raises again
    thr_wr = 1'b1; txe = 1'b0; step(); thr_wr = 1'b0;
    chk("R7 write leaves clear", 1'b0, 8'hC1, 8'h00);
    txe = 1'b1; step();
    chk("R6 empty edge after write", 1'b1, 8'hC2, 8'h60);
    // R7: THR write clears
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    chk("R7 thr write clears", 1'b0, 8'hC1, 8'h60);
    txe = 1'b0; step(); txe = 1'b1; step();
    chk("R6 re-armed by write", 1'b1, 8'hC2, 8'h60);
    // R10: polled mode
    ier = 3'b000; step();
    chk("R10 polled no request", 1'b0, 8'hC1, 8'h60);
    cnt = 5'd2; step();
    chk("R10 polled lsr updates", 1'b0, 8'hC1, 8'h61);
    ier = 3'b010; step();
    chk("R6 re-enable while empty", 1'b1, 8'hC2, 8'h61);

    // R9: line errors, priority over receive and transmit (R3)
    ier = 3'b111; trig = 2'd1;
    head_adv = 1'b1; head_err = 4'b0100; rx_push = 1'b1; push_err = 4'b0100;
    step();
    head_adv = 1'b0; head_err = 4'h0; rx_push = 1'b0; push_err = 4'h0;
    chk("R9 framing latched", 1'b1, 8'hC6, 8'hE9);
    cnt = 5'd4; step();
    chk("R3 line over receive", 1'b1, 8'hC6, 8'hE9);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    chk("R9 lsr read clears", 1'b1, 8'hC4, 8'h61);
    cnt = 5'd3; step();
    chk("R2 below level falls to transmit", 1'b1, 8'hC2, 8'h61);
    isr_rd = 1'b1; step(); isr_rd = 1'b0;
    chk("R7 isr read clears transmit", 1'b0, 8'hC1, 8'h61);
    head_adv = 1'b1; head_err = 4'b1000; step(); head_adv = 1'b0;
    chk("R9 break latched", 1'b1, 8'hC6, 8'h71);
    head_adv = 1'b1; head_err = 4'b0011; step(); head_adv = 1'b0;
    chk("R9 errors accumulate", 1'b1, 8'hC6, 8'h77);
    lsr_rd = 1'b1; head_adv = 1'b1; head_err = 4'b0010; step();
    lsr_rd = 1'b0; head_adv = 1'b0; head_err = 4'h0;
    chk("R9 same-cycle flag survives read", 1'b1, 8'hC6, 8'h65);
    ier = 3'b011; step();
    chk("R9 line source masked", 1'b0, 8'hC1, 8'h65);

    // R11: reset mid-run restores reset values
    rst = 1'b1; step(); rst = 1'b0;
    chk("R11 reset again", 1'b0, 8'h01, 8'h60);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule